// File: doc/BRIEF.md
# Histogram Percentile Thresholds for Grayscale Frames

This block watches one frame of 8-bit grayscale pixels and counts how many pixels fall on each of the 256 intensity levels. When the last pixel of the frame has been counted, it raises a one-cycle ready pulse. It then steps through the levels from 0 upward, one level per clock, and keeps a running total of the counts. From that total it picks two intensities. The lower one is the first level at which the running total covers at least 5 percent of the frame. The upper one is the first level at which it covers at least 95 percent. A contrast stretcher downstream uses the two levels as the ends of its input range.

The block never divides a count by the frame size. It compares the running total with two integer thresholds fixed at elaboration: the ceilings of 5·N/100 and 95·N/100, where N is FRAME_W·FRAME_H. The two results are held on the outputs, and a one-cycle done pulse marks the cycle in which they become valid. As the scan reads each level it also sets that count back to zero, so the next frame starts from an empty histogram without any extra clearing pass.

Top module: `cdf_percentile_finder`

## Requirements
- R1: While rstN is low and after it is released, histReady and resultDone are 0 and lowLevel and highLevel are 0.
- R2: While idle, the block counts no pixel until a valid pixel arrives with frameStart high. That pixel is the first one counted. Valid pixels without frameStart that arrive while idle are ignored.
- R3: The valid pixel that has frameEnd high is the last pixel counted. histReady is high for exactly one cycle, in the cycle right after the clock edge that takes this pixel.
- R4: resultDone is high for exactly one cycle. It rises 256 clock cycles after histReady rose.
- R5: At resultDone, lowLevel is the smallest level k whose cumulative count (the sum of bins 0..k) is at least ceil(5·N/100), where N = FRAME_W·FRAME_H.
- R6: At resultDone, highLevel is the smallest level k whose cumulative count is at least ceil(95·N/100).
- R7: If the frame's total count never reaches a threshold, that output is 255.
- R8: A frame in which every pixel has the same value v gives lowLevel = highLevel = v, including v = 0 and v = 255.
- R9: Between histReady and resultDone, every input pixel is ignored, including pixels that carry frameStart or frameEnd.
- R10: The scan leaves every bin at zero, so a frame's result depends only on that frame's own pixels.
- R11: lowLevel and highLevel change only on the edge that raises resultDone. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | High when pixData carries a pixel |
| pixData | input | PIX_W | Grayscale intensity |
| frameStart | input | 1 | Marks the first pixel of a frame |
| frameEnd | input | 1 | Marks the last pixel of a frame |
| histReady | output | 1 | One-cycle pulse when the histogram of the frame is complete |
| resultDone | output | 1 | One-cycle pulse when lowLevel and highLevel are updated |
| lowLevel | output | PIX_W | Level at the 5 percent point |
| highLevel | output | PIX_W | Level at the 95 percent point |

## Verification
The bench targets several boundary cases. One-level frames at 0, at 255 and in the middle test the off-by-one paths: a scan that records a level one step late, or misses the hit on the first level, gives the wrong value. A short frame that never reaches either threshold must give 255. Junk pixels sent before frameStart and during the scan test that the input is gated; a design that leaks them shifts the counts. A single-level frame sent right after a wide random frame exposes bins that were not cleared, because stale low bins would pull lowLevel below the real value.

// File: rtl/cdf_pct_pkg.sv
package cdf_pct_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_SCAN    = 2'd2
  } histState_t;

  typedef struct packed {
    logic countEn;
    logic scanEn;
    logic scanFirst;
    logic scanLast;
  } histCtrl_t;

endpackage

// File: rtl/cdf_pct_ctrl.sv
module cdf_pct_ctrl
  import cdf_pct_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             frameStart,
  input  logic             frameEnd,
  output histCtrl_t        ctrl,
  output logic [PIX_W-1:0] scanIdx,
  output logic             histReady,
  output logic             resultDone
);

  localparam logic [PIX_W-1:0] LAST_IDX = '1;

  histState_t state;

  always_comb begin
    ctrl.countEn   = pixValid && (((state == ST_IDLE) && frameStart) || (state == ST_COLLECT));
    ctrl.scanEn    = (state == ST_SCAN);
    ctrl.scanFirst = (state == ST_SCAN) && (scanIdx == '0);
    ctrl.scanLast  = (state == ST_SCAN) && (scanIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      scanIdx    <= '0;
      histReady  <= 1'b0;
      resultDone <= 1'b0;
    end else begin
      histReady  <= 1'b0;
      resultDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctrl.countEn) begin
            if (frameEnd) begin
              state     <= ST_SCAN;
              histReady <= 1'b1;
            end else begin
              state <= ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (pixValid && frameEnd) begin
            state     <= ST_SCAN;
            histReady <= 1'b1;
          end
        end
        ST_SCAN: begin
          scanIdx <= scanIdx + 1'b1;
          if (ctrl.scanLast) begin
            state      <= ST_IDLE;
            scanIdx    <= '0;
            resultDone <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cdf_pct_tracker.sv
module cdf_pct_tracker #(
  parameter int PIX_W = 8,
  parameter int CUM_W = 18,
  parameter int THR   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanEn,
  input  logic             scanFirst,
  input  logic             scanLast,
  input  logic [PIX_W-1:0] scanIdx,
  input  logic [CUM_W-1:0] cumNext,
  output logic [PIX_W-1:0] level
);

  localparam logic [CUM_W-1:0] THR_V = CUM_W'(THR);

  logic             found;
  logic             foundBase;
  logic             hit;
  logic [PIX_W-1:0] work;
  logic [PIX_W-1:0] workBase;
  logic [PIX_W-1:0] sel;

  // A new scan starts with nothing found and 255 as the fallback.
  always_comb begin
    foundBase = scanFirst ? 1'b0 : found;
    workBase  = scanFirst ? '1 : work;
    hit       = !foundBase && (cumNext >= THR_V);
    sel       = hit ? scanIdx : workBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      found <= 1'b0;
      work  <= '1;
      level <= '0;
    end else if (scanEn) begin
      found <= foundBase | hit;
      work  <= sel;
      if (scanLast) level <= sel;
    end
  end

endmodule

// File: rtl/cdf_pct_datapath.sv
module cdf_pct_datapath
  import cdf_pct_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int CNT_W  = 17,
  parameter int THR_LO = 1,
  parameter int THR_HI = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  histCtrl_t        ctrl,
  input  logic [PIX_W-1:0] pixData,
  input  logic [PIX_W-1:0] scanIdx,
  output logic [PIX_W-1:0] lowLevel,
  output logic [PIX_W-1:0] highLevel
);

  localparam int BINS  = 1 << PIX_W;
  localparam int CUM_W = CNT_W + 1;

  logic [CNT_W-1:0] binCnt [BINS];
  logic [CNT_W-1:0] binRd;
  logic [CUM_W-1:0] cum;
  logic [CUM_W-1:0] cumNext;
  logic [PIX_W-1:0] lvl [2];

  // Counting and clearing never overlap because they belong to different states.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BINS; i++) binCnt[i] <= '0;
    end else if (ctrl.countEn) begin
      binCnt[pixData] <= binCnt[pixData] + 1'b1;
    end else if (ctrl.scanEn) begin
      binCnt[scanIdx] <= '0;
    end
  end

  always_comb begin
    binRd   = binCnt[scanIdx];
    cumNext = (ctrl.scanFirst ? '0 : cum) + CUM_W'(binRd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cum <= '0;
    else if (ctrl.scanEn) cum <= cumNext;
  end

  for (genvar g = 0; g < 2; g++) begin : g_track
    localparam int THR_G = (g == 0) ? THR_LO : THR_HI;
    cdf_pct_tracker #(
      .PIX_W(PIX_W),
      .CUM_W(CUM_W),
      .THR  (THR_G)
    ) u_track (
      .clk      (clk),
      .rstN     (rstN),
      .scanEn   (ctrl.scanEn),
      .scanFirst(ctrl.scanFirst),
      .scanLast (ctrl.scanLast),
      .scanIdx  (scanIdx),
      .cumNext  (cumNext),
      .level    (lvl[g])
    );
  end

  assign lowLevel  = lvl[0];
  assign highLevel = lvl[1];

endmodule

// File: rtl/cdf_percentile_finder.sv
module cdf_percentile_finder
  import cdf_pct_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int PIX_W   = 8,
  parameter int LO_PCT  = 5,
  parameter int HI_PCT  = 95
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  input  logic             frameStart,
  input  logic             frameEnd,
  output logic             histReady,
  output logic             resultDone,
  output logic [PIX_W-1:0] lowLevel,
  output logic [PIX_W-1:0] highLevel
);

  localparam int FRAME_PIX = FRAME_W * FRAME_H;
  localparam int CNT_W     = $clog2(FRAME_PIX + 1);
  localparam int THR_LO    = (FRAME_PIX * LO_PCT + 99) / 100;
  localparam int THR_HI    = (FRAME_PIX * HI_PCT + 99) / 100;

  histCtrl_t        ctrl;
  logic [PIX_W-1:0] scanIdx;

  cdf_pct_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pixValid  (pixValid),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .ctrl      (ctrl),
    .scanIdx   (scanIdx),
    .histReady (histReady),
    .resultDone(resultDone)
  );

  cdf_pct_datapath #(
    .PIX_W (PIX_W),
    .CNT_W (CNT_W),
    .THR_LO(THR_LO),
    .THR_HI(THR_HI)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .pixData  (pixData),
    .scanIdx  (scanIdx),
    .lowLevel (lowLevel),
    .highLevel(highLevel)
  );

endmodule

// File: rtl/cdf_pct_checker.sv
module cdf_pct_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             histReady,
  input logic             resultDone,
  input logic [PIX_W-1:0] lowLevel,
  input logic [PIX_W-1:0] highLevel
);

  localparam int GAP_W = PIX_W + 2;
  localparam logic [GAP_W-1:0] SCAN_LEN = GAP_W'(1 << PIX_W);

  logic [GAP_W-1:0] gap;

  // Counts the cycles since histReady, so the scan length is checked without a deep $past.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gap <= '0;
    else if (histReady)     gap <= GAP_W'(1);
    else if (resultDone)    gap <= '0;
    else if (gap != '0)     gap <= gap + 1'b1;
  end

  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    histReady |=> !histReady);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |=> !resultDone);

  p_scan_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |-> (gap == SCAN_LEN));

  p_level_order_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultDone |-> (lowLevel <= highLevel));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !resultDone |-> ($stable(lowLevel) && $stable(highLevel)));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(histReady && resultDone));

endmodule

bind cdf_percentile_finder cdf_pct_checker #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .histReady (histReady),
  .resultDone(resultDone),
  .lowLevel  (lowLevel),
  .highLevel (highLevel)
);

// File: tb/test_cdf_percentile_finder.sv
`timescale 1ns/1ps
module test_cdf_percentile_finder;

  localparam int FW = 16;
  localparam int FH = 8;
  localparam int N  = FW * FH;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixData = '0;
  logic       frameStart = 1'b0;
  logic       frameEnd = 1'b0;
  logic       histReady;
  logic       resultDone;
  logic [7:0] lowLevel;
  logic [7:0] highLevel;

  int checks = 0;
  int errors = 0;
  int pixBuf [256];

  always #4 clk = ~clk;

  cdf_percentile_finder #(.FRAME_W(FW), .FRAME_H(FH)) i_cdf_percentile_finder (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixData(pixData),
    .frameStart(frameStart), .frameEnd(frameEnd), .histReady(histReady),
    .resultDone(resultDone), .lowLevel(lowLevel), .highLevel(highLevel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Smallest level whose cumulative count reaches ceil(pct*N/100), else 255.
  function automatic int refLevel(input int n, input int pct);
    int h [256];
    int thr;
    int cum;
    for (int i = 0; i < 256; i++) h[i] = 0;
    for (int i = 0; i < n; i++) h[pixBuf[i]]++;
    thr = (N * pct + 99) / 100;
    cum = 0;
    for (int k = 0; k < 256; k++) begin
      cum += h[k];
      if (cum >= thr) return k;
    end
    return 255;
  endfunction

  task automatic idle();
    pixValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic runFrame(input int n, input int gapPct, input int preJunk,
                          input bit scanJunk, input string tag);
    int expLo;
    int expHi;
    int cnt;
    expLo = refLevel(n, 5);
    expHi = refLevel(n, 95);
    for (int j = 0; j < preJunk; j++) begin
      @(negedge clk);
      pixValid = 1'b1; pixData = 8'($urandom); frameStart = 1'b0; frameEnd = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gapPct) begin
        @(negedge clk);
        idle(); pixData = 8'($urandom);
      end
      @(negedge clk);
      pixValid = 1'b1; pixData = 8'(pixBuf[i]);
      frameStart = (i == 0); frameEnd = (i == n - 1);
    end
    @(negedge clk);
    idle();
    check(histReady == 1'b1, {"R3 histReady after last pixel ", tag}, int'(histReady), 1);
    cnt = 0;
    do begin
      if (scanJunk) begin
        pixValid = 1'b1; pixData = 8'($urandom);
        frameStart = $urandom % 2; frameEnd = $urandom % 2;
      end
      @(negedge clk);
      cnt++;
      if (cnt == 1) check(histReady == 1'b0, {"R3 histReady one cycle ", tag}, int'(histReady), 0);
    end while (!resultDone && cnt < 400);
    idle();
    check(cnt == 256, {"R4 scan length ", tag}, cnt, 256);
    check(int'(lowLevel) == expLo, {"R5 lowLevel ", tag}, int'(lowLevel), expLo);
    check(int'(highLevel) == expHi, {"R6 highLevel ", tag}, int'(highLevel), expHi);
    @(negedge clk);
    check(resultDone == 1'b0, {"R4 done one cycle ", tag}, int'(resultDone), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_7a03));
    repeat (3) @(negedge clk);
    check(histReady == 0 && resultDone == 0, "R1 pulses low in reset", int'({histReady, resultDone}), 0);
    check(lowLevel == 0 && highLevel == 0, "R1 levels zero in reset", int'({lowLevel, highLevel}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(histReady == 0 && resultDone == 0, "R1 pulses low after reset", int'({histReady, resultDone}), 0);
    check(lowLevel == 0 && highLevel == 0, "R1 levels zero after reset", int'({lowLevel, highLevel}), 0);

    // R8: single-level frames at both ends and in the middle
    for (int i = 0; i < N; i++) pixBuf[i] = 77;
    runFrame(N, 0, 0, 0, "R8 uniform 77");
    check(lowLevel == highLevel, "R8 equal levels", int'(lowLevel), int'(highLevel));
    for (int i = 0; i < N; i++) pixBuf[i] = 0;
    runFrame(N, 20, 0, 0, "R8 uniform 0");
    for (int i = 0; i < N; i++) pixBuf[i] = 255;
    runFrame(N, 0, 0, 0, "R8 uniform 255");

    // R5/R6: random wide frames with gaps
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < N; i++) pixBuf[i] = $urandom % 256;
      runFrame(N, 30, 0, 0, "R5 R6 random wide");
    end
    // R10: single level 200 right after a wide frame; stale bins would lower lowLevel
    for (int i = 0; i < N; i++) pixBuf[i] = 200;
    runFrame(N, 0, 0, 0, "R10 after wide frame");

    // R5/R6: narrow band and two clusters near the 5 percent point
    for (int i = 0; i < N; i++) pixBuf[i] = 100 + ($urandom % 11);
    runFrame(N, 10, 0, 0, "R5 R6 narrow band");
    for (int i = 0; i < N; i++) pixBuf[i] = (i < 6) ? 3 : ((i < 7) ? 9 : 250);
    runFrame(N, 0, 0, 0, "R5 threshold boundary");
    for (int i = 0; i < N; i++) pixBuf[i] = ($urandom % 100 < 50) ? 12 : 240;
    runFrame(N, 15, 0, 0, "R5 R6 bimodal");

    // R7: short frame never reaches either threshold
    for (int i = 0; i < 5; i++) pixBuf[i] = 40;
    runFrame(5, 0, 0, 0, "R7 short frame");

    // R2 and R9: junk before frameStart and during the scan
    for (int i = 0; i < N; i++) pixBuf[i] = 60 + ($urandom % 50);
    runFrame(N, 10, 12, 1, "R2 R9 junk gated");

    // R11: outputs hold while idle junk without frameStart arrives
    begin
      int holdLo;
      int holdHi;
      bit sawPulse;
      holdLo = lowLevel; holdHi = highLevel; sawPulse = 0;
      for (int j = 0; j < 20; j++) begin
        @(negedge clk);
        if (histReady || resultDone) sawPulse = 1;
        pixValid = 1'b1; pixData = 8'($urandom); frameEnd = $urandom % 2;
      end
      @(negedge clk);
      idle();
      check(int'(lowLevel) == holdLo, "R11 lowLevel held", int'(lowLevel), holdLo);
      check(int'(highLevel) == holdHi, "R11 highLevel held", int'(highLevel), holdHi);
      check(!sawPulse, "R2 no pulse from idle junk", int'(sawPulse), 0);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule